// File: doc/BRIEF.md
# Rational-Ratio Clock Enable Generator

This block derives periodic single-cycle enable pulses from one free-running reference clock. The pulse rate is a rational fraction of the reference rate. A host sets the fraction as a 16-bit numerator and a 16-bit denominator, and the fraction carries a fixed scale of 1024. Two outputs are produced. The first is a multiplied-rate tick at 64, 128, 256 or 512 times a base rate. The second is the base tick, which fires on every M-th multiplied tick.

The host writes one byte at a time into shadow registers. The shadow values do nothing until the host flips the update bit in the control register. Either direction of the flip commits the shadow values into the working registers and restarts the pulse train from a known phase. A commit whose denominator is zero is refused.

A mode gate decides which ratio runs. The programmed ratio is used only in the custom rate-select setting. In every other setting a built-in ratio runs, which gives 48 kHz from 27 MHz. If a ratio asks for more than one multiplied tick per reference cycle, the output saturates and a sticky flag is raised.

Top module: `rate_enable_gen`

## Requirements
- R1: After reset all outputs are low. The shadow and working numerator are 2048, the denominator is 1125 and the multiplier select is 10b. The control register is otherwise zero, so the built-in ratio runs.
- R2: A write happens on a rising edge with `wr_en_i` high. The register addresses are:
  - Address 0: numerator low byte.
  - Address 1: numerator high byte.
  - Address 2: denominator low byte.
  - Address 3: denominator high byte.
  - Address 4: control. Bit 0 is the update bit, bits 3:1 are the rate select, bit 4 is the alternate-mode bit, and bits 6:5 are the multiplier select (00b=64, 01b=128, 10b=256, 11b=512).
- R3: Writes to the numerator, the denominator or the multiplier select have no effect on the outputs until bit 0 of the control register changes value.
- R4: A change of the update bit in either direction commits the shadow values. Counted from the rising edge that wrote the control register, the multiplied tick is low after the next edge. Over the first n edges, the tick count is floor((n-1)·Na·M/(1024·Da)).
- R5: While no restart occurs, the multiplied tick averages Na·M/(1024·Da) pulses per reference cycle, with at most one pulse per cycle.
- R6: The base tick pulses only together with a multiplied tick. It fires on every M-th multiplied tick counted from the last restart.
- R7: The programmed ratio runs only when the rate select is 100b and the alternate-mode bit is 0. Otherwise Na=2048 and Da=1125 are used with the committed multiplier. A change of this gate outcome restarts the phase as in R4.
- R8: When Na·M ≥ 1024·Da, the multiplied tick is high on every cycle after the restart edge and `overrange_o` is set. The flag stays set, across gate changes included, until the next accepted commit clears it.
- R9: A commit with a zero shadow denominator is rejected. The working ratio, the multiplier, the phase and the flag stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Register write data |
| mult_tick_o | output | 1 | Multiplied-rate enable pulse |
| base_tick_o | output | 1 | Base-rate enable pulse |
| overrange_o | output | 1 | Sticky saturation flag |

## Verification
The hardest state to reach is the sticky flag surviving a change of ratio that is not a commit. To get there, the ratio must first saturate through a committed overrange ratio, and then the gate must drop back to the built-in ratio without flipping the update bit. The stimulus builds this in two steps. It includes the exact boundary Na·M = 1024·Da. Random ratios then follow, with a bias toward small denominators so that saturation also occurs among the random cases. Tick counts are compared against a closed-form floor expression measured from each restart.

// File: rtl/rate_gen_pkg.sv
`timescale 1ns/1ps
package rate_gen_pkg;
  localparam int BYTE_W = 8;
  localparam int MSEL_W = 2;
  localparam logic [2:0] CUSTOM_SEL = 3'b100;

  typedef logic [MSEL_W-1:0] msel_t;

  typedef struct packed {
    msel_t      msel;
    logic       alt_en;
    logic [2:0] rate_sel;
    logic       upd;
  } ctrl_t;
endpackage

// File: rtl/rate_regfile.sv
`timescale 1ns/1ps
module rate_regfile import rate_gen_pkg::*; #(
  parameter int NUM_W    = 16,
  parameter int ADDR_W   = 3,
  parameter int DEF_NUM  = 2048,
  parameter int DEF_DEN  = 1125,
  parameter int DEF_MSEL = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [NUM_W-1:0]  num_o,
  output logic [NUM_W-1:0]  den_o,
  output msel_t             msel_o,
  output logic              restart_o,
  output logic              commit_ok_o
);
  localparam int NB = NUM_W / BYTE_W;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(2 * NB);

  logic [NUM_W-1:0] sh_num_q, sh_den_q, wk_num_q, wk_den_q;
  ctrl_t ctrl_q;
  msel_t wk_msel_q;
  logic  upd_seen_q, gate_q, gate_d, gate_chg, commit_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_num_q <= NUM_W'(DEF_NUM);
      sh_den_q <= NUM_W'(DEF_DEN);
      ctrl_q   <= '{msel: msel_t'(DEF_MSEL), alt_en: 1'b0, rate_sel: 3'b000, upd: 1'b0};
    end else if (wr_en_i) begin
      for (int b = 0; b < NB; b++) begin
        if (wr_addr_i == ADDR_W'(b))      sh_num_q[b*BYTE_W +: BYTE_W] <= wr_data_i;
        if (wr_addr_i == ADDR_W'(NB + b)) sh_den_q[b*BYTE_W +: BYTE_W] <= wr_data_i;
      end
      if (wr_addr_i == CTRL_ADDR) ctrl_q <= ctrl_t'(wr_data_i[$bits(ctrl_t)-1:0]);
    end
  end

  // edge of the update bit in either direction requests a commit
  assign commit_req  = ctrl_q.upd ^ upd_seen_q;
  assign commit_ok_o = commit_req && (sh_den_q != '0);
  assign gate_d      = (ctrl_q.rate_sel == CUSTOM_SEL) && !ctrl_q.alt_en;
  assign gate_chg    = gate_d ^ gate_q;
  assign restart_o   = commit_ok_o || gate_chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_seen_q <= 1'b0;
      gate_q     <= 1'b0;
      wk_num_q   <= NUM_W'(DEF_NUM);
      wk_den_q   <= NUM_W'(DEF_DEN);
      wk_msel_q  <= msel_t'(DEF_MSEL);
    end else begin
      upd_seen_q <= ctrl_q.upd;
      gate_q     <= gate_d;
      if (commit_ok_o) begin
        wk_num_q  <= sh_num_q;
        wk_den_q  <= sh_den_q;
        wk_msel_q <= ctrl_q.msel;
      end
    end
  end

  assign num_o  = gate_q ? wk_num_q : NUM_W'(DEF_NUM);
  assign den_o  = gate_q ? wk_den_q : NUM_W'(DEF_DEN);
  assign msel_o = wk_msel_q;

  a_r3_hold_without_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_req |=> $stable(wk_num_q) && $stable(wk_den_q) && $stable(wk_msel_q));

  a_r9_zero_den_rejected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_req && sh_den_q == '0) |=> $stable(wk_den_q) && $stable(wk_num_q) && $stable(wk_msel_q));

  a_r9_working_den_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wk_den_q != '0);
endmodule

// File: rtl/rate_accum.sv
`timescale 1ns/1ps
module rate_accum import rate_gen_pkg::*; #(
  parameter int NUM_W        = 16,
  parameter int FRAC_SHIFT   = 10,
  parameter int MIN_MULT_LOG = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NUM_W-1:0] num_i,
  input  logic [NUM_W-1:0] den_i,
  input  msel_t            msel_i,
  input  logic             restart_i,
  input  logic             commit_ok_i,
  output logic             tick_d_o,
  output logic             tick_o,
  output logic             overrange_o
);
  localparam int MAX_SH = FRAC_SHIFT - MIN_MULT_LOG;
  localparam int THR_W  = NUM_W + MAX_SH;
  localparam int ACC_W  = THR_W + 1;
  localparam int NSEL   = 2 ** MSEL_W;

  logic [ACC_W-1:0] thr_opt [NSEL];
  logic [ACC_W-1:0] thr, sum, acc_q;
  logic over, wrap;

  // wrap threshold Da*1024/M for each multiplier
  for (genvar m = 0; m < NSEL; m++) begin : g_thr
    assign thr_opt[m] = ACC_W'(den_i) << (MAX_SH - m);
  end

  assign thr      = thr_opt[msel_i];
  assign over     = ACC_W'(num_i) >= thr;
  assign sum      = acc_q + ACC_W'(num_i);
  assign wrap     = sum >= thr;
  assign tick_d_o = !restart_i && (over || wrap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q       <= '0;
      tick_o      <= 1'b0;
      overrange_o <= 1'b0;
    end else begin
      tick_o <= tick_d_o;
      if (restart_i) begin
        acc_q <= '0;
        if (commit_ok_i) overrange_o <= 1'b0;
      end else if (over) begin
        acc_q       <= '0;
        overrange_o <= 1'b1;
      end else if (wrap) begin
        acc_q <= sum - thr;
      end else begin
        acc_q <= sum;
      end
    end
  end

  a_r5_acc_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q < thr);

  a_r8_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrange_o && !commit_ok_i) |=> overrange_o);

  a_r8_flag_on_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (over && !restart_i) |=> overrange_o && tick_o);

  a_r4_restart_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !tick_o);
endmodule

// File: rtl/rate_divider.sv
`timescale 1ns/1ps
module rate_divider import rate_gen_pkg::*; #(
  parameter int MIN_MULT_LOG = 6
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_d_i,
  input  msel_t msel_i,
  input  logic  restart_i,
  output logic  base_o
);
  localparam int NSEL  = 2 ** MSEL_W;
  localparam int CNT_W = MIN_MULT_LOG + NSEL - 1;

  logic [CNT_W-1:0] last_opt [NSEL];
  logic [CNT_W-1:0] last, cnt_q;

  for (genvar m = 0; m < NSEL; m++) begin : g_last
    assign last_opt[m] = CNT_W'((1 << (MIN_MULT_LOG + m)) - 1);
  end
  assign last = last_opt[msel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      base_o <= 1'b0;
    end else if (restart_i) begin
      cnt_q  <= '0;
      base_o <= 1'b0;
    end else if (tick_d_i) begin
      if (cnt_q == last) begin
        cnt_q  <= '0;
        base_o <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        base_o <= 1'b0;
      end
    end else begin
      base_o <= 1'b0;
    end
  end

  a_r6_count_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last);
endmodule

// File: rtl/rate_enable_gen.sv
`timescale 1ns/1ps
module rate_enable_gen import rate_gen_pkg::*; #(
  parameter int NUM_W        = 16,
  parameter int ADDR_W       = 3,
  parameter int FRAC_SHIFT   = 10,
  parameter int MIN_MULT_LOG = 6,
  parameter int DEF_NUM      = 2048,
  parameter int DEF_DEN      = 1125,
  parameter int DEF_MSEL     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic              mult_tick_o,
  output logic              base_tick_o,
  output logic              overrange_o
);
  logic [NUM_W-1:0] num, den;
  msel_t msel;
  logic  restart, commit_ok, tick_d;

  rate_regfile #(
    .NUM_W(NUM_W), .ADDR_W(ADDR_W),
    .DEF_NUM(DEF_NUM), .DEF_DEN(DEF_DEN), .DEF_MSEL(DEF_MSEL)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .num_o(num), .den_o(den), .msel_o(msel),
    .restart_o(restart), .commit_ok_o(commit_ok)
  );

  rate_accum #(
    .NUM_W(NUM_W), .FRAC_SHIFT(FRAC_SHIFT), .MIN_MULT_LOG(MIN_MULT_LOG)
  ) u_acc (
    .clk_i, .rst_ni, .num_i(num), .den_i(den), .msel_i(msel),
    .restart_i(restart), .commit_ok_i(commit_ok),
    .tick_d_o(tick_d), .tick_o(mult_tick_o), .overrange_o(overrange_o)
  );

  rate_divider #(.MIN_MULT_LOG(MIN_MULT_LOG)) u_div (
    .clk_i, .rst_ni, .tick_d_i(tick_d), .msel_i(msel),
    .restart_i(restart), .base_o(base_tick_o)
  );

  a_r6_base_with_mult: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_tick_o |-> mult_tick_o);
endmodule

// File: tb/rate_enable_gen_test.sv
`timescale 1ns/1ps
module rate_enable_gen_test;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic mult_tick_o, base_tick_o, overrange_o;

  always #4 clk_i = ~clk_i;

  rate_enable_gen uut (.*);

  int checks = 0, fails = 0;
  bit done = 1'b0;
  longint cyc = 0, mc = 0, bc = 0, cyc0 = 0, mc0 = 0, bc0 = 0;

  // bench model of committed state, built from the requirements
  bit b_upd = 1'b0, gate = 1'b0, flag_exp = 1'b0;
  longint sh_num = 2048, sh_den = 1125, w_num = 2048, w_den = 1125;
  int w_msel = 2;

  always @(negedge clk_i) begin
    cyc++;
    if (mult_tick_o) mc++;
    if (base_tick_o) bc++;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic set_ratio(input longint na, input longint da);
    wr(3'd0, na[7:0]);  wr(3'd1, na[15:8]);
    wr(3'd2, da[7:0]);  wr(3'd3, da[15:8]);
    sh_num = na; sh_den = da;
  endtask

  task automatic write_ctrl(input bit [2:0] rsel, input bit alt, input bit [1:0] ms, input bit toggle);
    bit ok, ng, rs;
    if (toggle) b_upd = ~b_upd;
    wr(3'd4, {1'b0, ms, alt, rsel, b_upd});
    ok = toggle && (sh_den != 0);
    if (ok) begin
      w_num = sh_num; w_den = sh_den; w_msel = ms; flag_exp = 1'b0;
    end
    ng = (rsel == 3'b100) && !alt;
    rs = ok || (ng != gate);
    gate = ng;
    #1;
    if (rs) begin cyc0 = cyc; mc0 = mc; bc0 = bc; end
  endtask

  function automatic longint exp_ticks(input longint j, input longint na, input longint da, input longint m);
    if (na * m >= 1024 * da) return j;
    return (j * na * m) / (1024 * da);
  endfunction

  task automatic check_window(input int n, input string tag);
    longint na, da, m, j, em;
    repeat (n) @(negedge clk_i);
    #1;
    na = gate ? w_num : 2048;
    da = gate ? w_den : 1125;
    m  = 64 << w_msel;
    j  = cyc - cyc0 - 1;
    if (na * m >= 1024 * da && j >= 1) flag_exp = 1'b1;
    em = exp_ticks(j, na, da, m);
    chk({tag, " mult count"}, mc - mc0, em);
    chk({tag, " base count"}, bc - bc0, em / m);
    chk({tag, " flag"}, longint'(overrange_o), longint'(flag_exp));
  endtask

  initial begin
    #1600000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL R4 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    longint na, da;
    int ms;
    void'($urandom(32'd4911));
    repeat (3) @(negedge clk_i);
    chk("R1 reset mult", longint'(mult_tick_o), 0);
    chk("R1 reset base", longint'(base_tick_o), 0);
    chk("R1 reset flag", longint'(overrange_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // reset shadow values committed: 2048/1125, M=256
    write_ctrl(3'b100, 1'b0, 2'd2, 1'b1);
    check_window(3000, "R1 R2 R4 R6 reset shadow");

    // shadow writes without a toggle leave the rate alone
    set_ratio(1792, 1125);
    write_ctrl(3'b100, 1'b0, 2'd3, 1'b0);
    check_window(1000, "R3 held");

    // falling update bit commits
    write_ctrl(3'b100, 1'b0, 2'd3, 1'b1);
    check_window(2500, "R4 falling toggle R5");

    write_ctrl(3'b100, 1'b1, 2'd3, 1'b0);
    check_window(1500, "R7 alternate bit");
    write_ctrl(3'b101, 1'b0, 2'd3, 1'b0);
    check_window(1500, "R7 other select");
    write_ctrl(3'b100, 1'b0, 2'd3, 1'b0);
    check_window(1500, "R7 custom restored");

    set_ratio(5000, 0);
    write_ctrl(3'b100, 1'b0, 2'd0, 1'b1);
    check_window(1500, "R9 zero den");

    set_ratio(65535, 100);
    write_ctrl(3'b100, 1'b0, 2'd3, 1'b1);
    check_window(600, "R8 overrange");
    set_ratio(2048, 128);
    write_ctrl(3'b100, 1'b0, 2'd0, 1'b1);
    check_window(600, "R8 equal bound");

    write_ctrl(3'b000, 1'b0, 2'd0, 1'b0);
    check_window(1500, "R8 sticky R7");

    set_ratio(1000, 3000);
    write_ctrl(3'b100, 1'b0, 2'd1, 1'b1);
    check_window(1500, "R8 cleared R5");

    for (int i = 0; i < 10; i++) begin
      na = $urandom_range(65535, 1);
      da = (i % 3 == 2) ? $urandom_range(300, 1) : $urandom_range(65535, 1);
      ms = $urandom_range(3, 0);
      set_ratio(na, da);
      write_ctrl(3'b100, 1'b0, 2'(ms), 1'b1);
      check_window(1500 + int'($urandom_range(1000, 0)), "R5 R6 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule